// File: doc/BRIEF.md
# Buffered Factory-Program Command Engine

This block is the device-side command engine of a NOR-style flash array for a high-throughput manufacturing programming mode. A host on a simple synchronous bus writes a two-word command sequence to enter the mode. It then streams sixteen-bit words that the engine collects in a 32-word buffer. When the buffer is full, the engine programs the words into the array one by one through a behavioural program port. Each word is verified, and a word that fails verification is programmed again, up to a bounded number of attempts.

The host keeps writing to the same start address while an internal slot pointer advances. After each buffer is programmed, the engine moves on to the next 32-word window of the same block without a new command. A write to any address outside the block ends the mode. Once the mode is entered, every read returns a status word with a ready flag, a busy flag and a sticky error flag. A single input, asserted by the environment, states that supply and temperature conditions are in range. A per-block lock vector protects blocks from being programmed. Outside the mode, reads return array data unless status reads have been selected.

Top module: `fbp_engine`

## Requirements
- R1: After reset the engine is idle, `arr_start` is low and reads with `bus_re` high return `arr_rdata` (array-read view).
- R2: In idle, a write whose low byte is 0x80 arms the engine. The next write enters the mode only if its low byte is 0xD0 and `cond_ok` is high. Otherwise the error flag is set and the engine returns to idle. From that second write onward, reads return the status word.
- R3: Inside the mode, written words are stored as program data and never decoded. Values 0x0050, 0x0070, 0x0080, 0x00B0, 0x00D0 and 0x00FF reach the array unchanged.
- R4: If the first data write after entry has a nonzero address in bits [4:0], the error flag is set, the engine returns to idle and no array operation starts.
- R5: If `blk_lock` bit (address bits [15:10]) is set for the first data write, the error flag is set, the engine returns to idle and the array is left untouched.
- R6: Each write inside the start block fills the next buffer slot. The first write of the mode fills slot 0 and sets the window base to its address. After slot 31 is filled, words are programmed in ascending order at base+i. Each word gets a one-cycle `arr_start`, with `arr_addr`/`arr_wdata` held until `arr_done`.
- R7: When `arr_done` comes with `arr_verify_ok` low, the same word is started again. After 8 failed attempts on one word, the error flag is set, the engine returns to idle and no further `arr_start` is issued.
- R8: After a window is programmed, the engine accepts the next window at base+32 without a new command. After the last window of the 1024-word block, it returns to idle by itself.
- R9: A write to an address outside the start block while filling ends the mode without changing the error flag. The partly filled buffer is discarded.
- R10: The status word has bit 7 = idle/ready, bit 4 = error and bit 0 = programming busy, with all other bits 0. Any read with `bus_re` low returns 0.
- R11: Writes that arrive while a window is being programmed are dropped, including one in the cycle of the final `arr_done`.
- R12: In idle, low byte 0x50 clears the error flag, 0x70 selects status reads and 0xFF selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle held high |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (status or array) |
| cond_ok | input | 1 | Supply and temperature conditions in range |
| blk_lock | input | 64 | Per-block lock bits |
| arr_rdata | input | 16 | Array read data for `bus_addr` |
| arr_addr | output | 16 | Array program address |
| arr_wdata | output | 16 | Array program data |
| arr_start | output | 1 | One-cycle program start |
| arr_done | input | 1 | Program and verify of a word finished |
| arr_verify_ok | input | 1 | Verify result, valid with `arr_done` |

## Verification
A bus write can land in the same cycle in which the array reports the final verified word of a window. At that moment, the engine switches from programming back to filling. The bench provokes this by holding the write strobe high through the whole programming interval and releasing it only once the busy bit is seen low. The write in the completion cycle must therefore be dropped, and the next window's slot 0 must hold the first word written afterwards. The reference model and the array contents at the next window base judge this cycle by cycle.

// File: rtl/fbp_pkg.sv
// Shared types and command codes of the buffered factory-program engine.
// Assumes commands are carried in the low byte of a bus write.
package fbp_pkg;
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_FIRST,
        ENG_FILL,
        ENG_PROG
    } eng_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_t;

    localparam logic [7:0] CMD_ARM     = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLRERR  = 8'h50;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    localparam int ST_READY_BIT = 7;
    localparam int ST_ERR_BIT   = 4;
    localparam int ST_BUSY_BIT  = 0;
endpackage

// File: rtl/fbp_wbuf.sv
// Word buffer of the factory-program engine: one write port, one
// asynchronous read port. Assumes the contents need no reset, because every
// slot is written before the sequencer reads it.
module fbp_wbuf #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slots [DEPTH];

    // Store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/fbp_prog_seq.sv
// Program sequencer: walks the buffer from slot 0 upward and issues one
// array start per word. It holds address and data until the array reports
// done, restarts a word that fails verify, and gives up after MAX_TRIES
// failures. Assumes base stays stable while a pass is running.
module fbp_prog_seq
    import fbp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int DEPTH     = 32,
    parameter int MAX_TRIES = 8,
    localparam int IW       = $clog2(DEPTH),
    localparam int TW       = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] base,
    output logic [IW-1:0] buf_idx,
    input  logic [DW-1:0] buf_data,
    input  logic          arr_done,
    input  logic          arr_ok,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_start,
    output logic          done,
    output logic          fail
);
    seq_state_t    st;
    logic [IW-1:0] idx;
    logic [TW-1:0] tries;
    logic          last_word;
    logic          last_try;

    assign last_word = (idx == IW'(DEPTH - 1));
    assign last_try  = (tries == TW'(MAX_TRIES - 1));
    assign buf_idx   = idx;
    assign arr_addr  = base + {{(AW-IW){1'b0}}, idx};
    assign arr_wdata = buf_data;
    assign arr_start = (st == SQ_ISSUE);
    assign done      = (st == SQ_WAIT) && arr_done && arr_ok && last_word;
    assign fail      = (st == SQ_WAIT) && arr_done && !arr_ok && last_try;

    // Word walk, retry counting and issue/wait sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_IDLE;
            idx   <= '0;
            tries <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (go) begin
                        idx   <= '0;
                        tries <= '0;
                        st    <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (arr_done) begin
                        if (arr_ok) begin
                            if (last_word) begin
                                st <= SQ_IDLE;
                            end else begin
                                idx   <= idx + 1'b1;
                                tries <= '0;
                                st    <= SQ_ISSUE;
                            end
                        end else if (last_try) begin
                            st <= SQ_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= SQ_ISSUE;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R6: address and data stay put while a word is in flight.
    assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT && !arr_done) |=> ($stable(arr_addr) && $stable(arr_wdata)));

    // R6: a start lasts exactly one cycle.
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start);

    // R7: the failure counter never passes its bound.
    assert_try_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tries < TW'(MAX_TRIES));

    // R7: a failed verify restarts the same word.
    assert_retry_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT && arr_done && !arr_ok && !last_try) |=> (arr_start && $stable(arr_addr)));
endmodule

// File: rtl/fbp_engine.sv
// Buffered factory-program command engine (top). It decodes the arm and
// confirm writes, checks alignment and block lock on the first data word,
// fills the word buffer from writes at a fixed address, hands full buffers
// to the program sequencer, and exits on a write outside the start block.
// It also keeps the ready, busy and error status bits. Assumes commands sit
// in the low data byte and that one write is taken per cycle with bus_we high.
module fbp_engine
    import fbp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BLK_AW    = 10,
    parameter int BUF_WORDS = 32,
    parameter int MAX_TRIES = 8,
    localparam int DW       = 16,
    localparam int IW       = $clog2(BUF_WORDS),
    localparam int BW       = AW - BLK_AW,
    localparam int NBLK     = 1 << BW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic            bus_re,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            cond_ok,
    input  logic [NBLK-1:0] blk_lock,
    input  logic [DW-1:0]   arr_rdata,
    output logic [AW-1:0]   arr_addr,
    output logic [DW-1:0]   arr_wdata,
    output logic            arr_start,
    input  logic            arr_done,
    input  logic            arr_verify_ok
);
    eng_state_t    state;
    logic          err;
    logic          rd_stat;
    logic [BW-1:0] start_blk;
    logic [AW-1:0] win_base;
    logic [IW-1:0] ptr;

    logic [BW-1:0] wr_blk;
    logic          in_blk;
    logic          aligned;
    logic          locked;
    logic [7:0]    cmd;
    logic          win_last;
    logic          buf_we;
    logic [IW-1:0] buf_widx;
    logic [IW-1:0] buf_ridx;
    logic [DW-1:0] buf_rdata;
    logic          seq_go;
    logic          seq_done;
    logic          seq_fail;
    logic [DW-1:0] status;
    logic          show_stat;

    assign wr_blk   = bus_addr[AW-1:BLK_AW];
    assign in_blk   = (wr_blk == start_blk);
    assign aligned  = (bus_addr[IW-1:0] == '0);
    assign locked   = blk_lock[wr_blk];
    assign cmd      = bus_wdata[7:0];
    assign win_last = &win_base[BLK_AW-1:IW];

    assign buf_we   = bus_we && (((state == ENG_FIRST) && aligned && !locked)
                                 || ((state == ENG_FILL) && in_blk));
    assign buf_widx = (state == ENG_FIRST) ? '0 : ptr;
    assign seq_go   = bus_we && (state == ENG_FILL) && in_blk && (ptr == IW'(BUF_WORDS - 1));

    fbp_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) u_wbuf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (buf_widx),
        .wr_data (bus_wdata),
        .rd_idx  (buf_ridx),
        .rd_data (buf_rdata)
    );

    fbp_prog_seq #(.AW(AW), .DW(DW), .DEPTH(BUF_WORDS), .MAX_TRIES(MAX_TRIES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (seq_go),
        .base      (win_base),
        .buf_idx   (buf_ridx),
        .buf_data  (buf_rdata),
        .arr_done  (arr_done),
        .arr_ok    (arr_verify_ok),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .arr_start (arr_start),
        .done      (seq_done),
        .fail      (seq_fail)
    );

    // Status word and read mux.
    always_comb begin
        status               = '0;
        status[ST_READY_BIT] = (state == ENG_IDLE);
        status[ST_ERR_BIT]   = err;
        status[ST_BUSY_BIT]  = (state == ENG_PROG);
        show_stat = rd_stat || (state == ENG_FIRST) || (state == ENG_FILL) || (state == ENG_PROG);
        if (!bus_re)        bus_rdata = '0;
        else if (show_stat) bus_rdata = status;
        else                bus_rdata = arr_rdata;
    end

    // Command decode, mode phases, fill pointer and window advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            err       <= 1'b0;
            rd_stat   <= 1'b0;
            start_blk <= '0;
            win_base  <= '0;
            ptr       <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (bus_we) begin
                        case (cmd)
                            CMD_ARM:    state   <= ENG_SETUP;
                            CMD_CLRERR: err     <= 1'b0;
                            CMD_STATUS: rd_stat <= 1'b1;
                            CMD_ARRAY:  rd_stat <= 1'b0;
                            default:    ;
                        endcase
                    end
                end
                ENG_SETUP: begin
                    if (bus_we) begin
                        rd_stat <= 1'b1;
                        if (cmd == CMD_CONFIRM && cond_ok) begin
                            state <= ENG_FIRST;
                        end else begin
                            err   <= 1'b1;
                            state <= ENG_IDLE;
                        end
                    end
                end
                ENG_FIRST: begin
                    if (bus_we) begin
                        if (!aligned || locked) begin
                            err   <= 1'b1;
                            state <= ENG_IDLE;
                        end else begin
                            start_blk <= wr_blk;
                            win_base  <= bus_addr;
                            ptr       <= IW'(1);
                            state     <= ENG_FILL;
                        end
                    end
                end
                ENG_FILL: begin
                    if (bus_we) begin
                        if (!in_blk) begin
                            state <= ENG_IDLE;
                        end else if (ptr == IW'(BUF_WORDS - 1)) begin
                            ptr   <= '0;
                            state <= ENG_PROG;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ENG_PROG: begin
                    if (seq_fail) begin
                        err   <= 1'b1;
                        state <= ENG_IDLE;
                    end else if (seq_done) begin
                        if (win_last) begin
                            state <= ENG_IDLE;
                        end else begin
                            win_base <= win_base + AW'(BUF_WORDS);
                            state    <= ENG_FILL;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R11: the array is driven only while a window is programming.
    assert_start_in_prog_R11: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> (state == ENG_PROG));

    // R4: a misaligned first word aborts with the error flag.
    assert_misalign_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_FIRST && bus_we && !aligned) |=> (state == ENG_IDLE && err));

    // R5: a locked block aborts with the error flag.
    assert_lock_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_FIRST && bus_we && locked) |=> (state == ENG_IDLE && err));

    // R9: leaving the block ends the mode without touching the error flag.
    assert_exit_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_FILL && bus_we && !in_blk) |=> (state == ENG_IDLE && $stable(err)));

    // R7: an exhausted retry budget raises the error flag and stops.
    assert_retry_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fail |=> (err && state == ENG_IDLE));
endmodule

// File: tb/sim_fbp_engine.sv
// Bench: behavioural reference model compared on every clock, plus an
// array responder with verify-failure injection and scenario checks.
module sim_fbp_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic        re = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cond_ok = 1'b1;
    logic [63:0] lock_v = '0;
    logic [15:0] arr_rd = 16'hA5A5;
    logic [15:0] arr_addr;
    logic [15:0] arr_wdata;
    logic        arr_start;
    logic        arr_done = 1'b0;
    logic        arr_ok = 1'b1;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;

    fbp_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .cond_ok(cond_ok), .blk_lock(lock_v),
        .arr_rdata(arr_rd), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_start(arr_start), .arr_done(arr_done), .arr_verify_ok(arr_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Array responder: done one cycle after start, optional verify failures.
    int          fail_budget = 0;
    int          start_count = 0;
    int          mem [int];
    bit          pend = 0;
    logic [15:0] p_addr, p_data;
    always @(negedge clk) begin
        arr_done = pend;
        arr_ok   = 1'b1;
        if (pend) begin
            if (fail_budget > 0) begin
                arr_ok = 1'b0;
                fail_budget--;
            end else begin
                mem[int'(p_addr)] = int'(p_data);
            end
        end
        pend = arr_start;
        if (arr_start) begin
            start_count++;
            p_addr = arr_addr;
            p_data = arr_wdata;
        end
    end

    // Reference model: modes 0 idle, 1 armed, 2 first word, 3 filling, 4 programming.
    int          m_mode = 0, m_blk = 0, m_base = 0, m_idx = 0, m_tries = 0;
    bit          m_err = 0, m_rds = 0, m_issue = 0;
    logic [15:0] m_buf [$];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_err = 0; m_rds = 0; m_issue = 0; m_buf.delete();
        end else begin
            case (m_mode)
                0: if (we) begin
                    if (wdata[7:0] == 8'h80) m_mode = 1;
                    else if (wdata[7:0] == 8'h50) m_err = 0;
                    else if (wdata[7:0] == 8'h70) m_rds = 1;
                    else if (wdata[7:0] == 8'hFF) m_rds = 0;
                end
                1: if (we) begin
                    m_rds = 1;
                    if (wdata[7:0] == 8'hD0 && cond_ok) m_mode = 2;
                    else begin m_err = 1; m_mode = 0; end
                end
                2: if (we) begin
                    if ((int'(addr) % 32) != 0 || lock_v[int'(addr) / 1024]) begin
                        m_err = 1; m_mode = 0;
                    end else begin
                        m_blk = int'(addr) / 1024; m_base = int'(addr);
                        m_buf.delete(); m_buf.push_back(wdata); m_mode = 3;
                    end
                end
                3: if (we) begin
                    if (int'(addr) / 1024 != m_blk) begin
                        m_mode = 0; m_buf.delete();
                    end else begin
                        m_buf.push_back(wdata);
                        if (m_buf.size() == 32) begin
                            m_mode = 4; m_idx = 0; m_tries = 0; m_issue = 1;
                        end
                    end
                end
                default: begin
                    if (m_issue) m_issue = 0;
                    else if (arr_done) begin
                        if (arr_ok) begin
                            if (m_idx == 31) begin
                                m_buf.delete();
                                if ((m_base + 32) % 1024 == 0) m_mode = 0;
                                else begin m_base += 32; m_mode = 3; end
                            end else begin
                                m_idx++; m_tries = 0; m_issue = 1;
                            end
                        end else if (m_tries == 7) begin
                            m_err = 1; m_mode = 0; m_buf.delete();
                        end else begin
                            m_tries++; m_issue = 1;
                        end
                    end
                end
            endcase
        end
    end

    // Per-cycle comparison, a quarter period after the active edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (chk_on) begin
            logic [15:0] st, er;
            bit          es;
            st = {8'h00, (m_mode == 0), 2'b00, m_err, 3'b000, (m_mode == 4)};
            if (!re) er = 16'h0000;
            else if (m_rds || m_mode >= 2) er = st;
            else er = arr_rd;
            check(rdata == er, "R10 read data", rdata, er);
            es = (m_mode == 4) && m_issue;
            check(arr_start == es, "R6 start", arr_start, es);
            if (es) begin
                check(arr_addr == 16'(m_base + m_idx), "R6 address", arr_addr, m_base + m_idx);
                check(arr_wdata == m_buf[m_idx], "R3 data", arr_wdata, m_buf[m_idx]);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wait_idle_prog();
        while (rdata[0]) @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int w, input int i);
        return 16'(w * 97 + i * 13 + 16'h1234);
    endfunction

    task automatic fill_window(input logic [15:0] a, input int w);
        for (int i = 0; i < 32; i++) wr(a, pat(w, i));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1;
        // R1: reset state
        check(rdata == 16'hA5A5, "R1 array read after reset", rdata, 16'hA5A5);
        check(arr_start == 1'b0, "R1 no start after reset", arr_start, 0);

        // R2: wrong confirm code
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h0033);
        @(negedge clk);
        check(rdata == 16'h0090, "R2 bad confirm error", rdata, 16'h0090);
        // R12: clear error, then array view
        wr(16'h0000, 16'h0050);
        check(rdata == 16'h0080, "R12 error cleared", rdata, 16'h0080);
        wr(16'h0000, 16'h00FF);
        check(rdata == 16'hA5A5, "R12 array view", rdata, 16'hA5A5);

        // R2: conditions not met
        cond_ok = 1'b0;
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h00D0);
        check(rdata == 16'h0090, "R2 conditions error", rdata, 16'h0090);
        cond_ok = 1'b1;
        wr(16'h0000, 16'h0050);

        // R4: misaligned start
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h00D0);
        check(rdata == 16'h0000, "R2 in mode status", rdata, 16'h0000);
        wr(16'h0405, 16'h1111);
        check(rdata == 16'h0090, "R4 misaligned error", rdata, 16'h0090);
        check(start_count == 0, "R4 no array op", start_count, 0);
        wr(16'h0000, 16'h0050);

        // R5: locked block
        lock_v[3] = 1'b1;
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h00D0);
        wr(16'h0C00, 16'h2222);
        check(rdata == 16'h0090, "R5 locked error", rdata, 16'h0090);
        check(!mem.exists(16'h0C00), "R5 array unchanged", start_count, 0);
        wr(16'h0000, 16'h0050);

        // R3, R6, R7: first window with commands as data and 3 verify failures
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h00D0);
        fail_budget = 3;
        wr(16'h0400, pat(0, 0));
        wr(16'h0400, 16'h0050); wr(16'h0400, 16'h0070); wr(16'h0400, 16'h0080);
        wr(16'h0400, 16'h00B0); wr(16'h0400, 16'h00D0); wr(16'h0400, 16'h00FF);
        for (int i = 7; i < 32; i++) wr(16'h0400, pat(0, i));
        check(rdata == 16'h0001, "R10 busy status", rdata, 16'h0001);
        wait_idle_prog();
        check(mem[16'h0400] == int'(pat(0, 0)), "R7 retried word", mem[16'h0400], pat(0, 0));
        check(mem[16'h0402] == 16'h0070, "R3 status code stored", mem[16'h0402], 16'h0070);
        check(mem[16'h0406] == 16'h00FF, "R3 array code stored", mem[16'h0406], 16'h00FF);
        check(mem[16'h041F] == int'(pat(0, 31)), "R6 last word", mem[16'h041F], pat(0, 31));
        check(start_count == 35, "R7 start count", start_count, 35);

        // R8, R11: second window, flood writes through programming
        fill_window(16'h0400, 1);
        we = 1'b1; addr = 16'h0400; wdata = 16'hDEAD;
        while (rdata[0]) @(negedge clk);
        we = 1'b0;
        fill_window(16'h0400, 2);
        wait_idle_prog();
        check(mem[16'h0420] == int'(pat(1, 0)), "R8 second window", mem[16'h0420], pat(1, 0));
        check(mem[16'h0440] == int'(pat(2, 0)), "R11 flood dropped", mem[16'h0440], pat(2, 0));

        // R9: partial window then out-of-block write
        for (int i = 0; i < 5; i++) wr(16'h0400, pat(3, i));
        wr(16'h2000, 16'h5555);
        check(rdata == 16'h0080, "R9 clean exit", rdata, 16'h0080);
        check(!mem.exists(16'h0460), "R9 partial discarded", 1, 0);

        // R7: retry exhaustion
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h00D0);
        begin
            int base_cnt;
            base_cnt = start_count;
            fail_budget = 8;
            fill_window(16'h0800, 4);
            wait_idle_prog();
            repeat (4) @(negedge clk);
            check(rdata == 16'h0090, "R7 exhausted error", rdata, 16'h0090);
            check(start_count - base_cnt == 8, "R7 eight attempts", start_count - base_cnt, 8);
            check(!mem.exists(16'h0800), "R7 no write", 1, 0);
        end
        wr(16'h0000, 16'h0050);

        // R8: whole block, automatic exit
        wr(16'h0000, 16'h0080); wr(16'h0000, 16'h00D0);
        for (int w = 0; w < 32; w++) begin
            fill_window(16'h1400, 10 + w);
            wait_idle_prog();
        end
        check(rdata == 16'h0080, "R8 auto exit", rdata, 16'h0080);
        check(mem[16'h17FF] == int'(pat(41, 31)), "R8 final word", mem[16'h17FF], pat(41, 31));

        // R10: read strobe low
        re = 1'b0;
        @(negedge clk);
        check(rdata == 16'h0000, "R10 no read", rdata, 0);
        re = 1'b1;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule